// File: doc/BRIEF.md
# Extended-Precision to Single/Double Float Narrowing Converter

This block takes an 80-bit extended-precision floating-point value and narrows it to either a 32-bit single or a 64-bit double result. A format select input picks the output format. Rounding follows a 2-bit rounding-control input. The block takes one conversion per cycle, and the result is registered one clock after the request.

Besides the converted word, the block reports two more things:
- a store-enable that tells the surrounding store path whether the word may be written;
- three sticky exception flags, for precision, underflow and overflow, which accumulate until reset.

Zeros, infinities and NaNs are narrowed by truncation, so they keep their identity. Finite values are re-biased and rounded. Results in the destination's denormal range are reported through the underflow flag only.

The supported input encodings have the integer bit set whenever the exponent is nonzero and not all ones. An input with a zero exponent field is a denormal and is converted from its true value.

Top module: `ext_fp_store`

## Requirements
- R1: While rst_ni is low, and until the first request after it rises, valid_o, store_en_o, result_o and flags_o are all zero.
- R2: A request with valid_i high produces valid_o high exactly one clock later. An exactly representable finite input is re-biased: 127 with fields 8/23 for single, 1023 with fields 11/52 for double.
- R3: rnd_i selects the rounding of finite results:
  - 00 rounds to nearest, ties to even;
  - 01 rounds toward minus infinity;
  - 10 rounds toward plus infinity;
  - 11 rounds toward zero.
  A carry out of the significand increments the exponent.
- R4: Any finite conversion that loses bits sets flags_o[0] (precision). The flag bit positions are [0] precision, [1] underflow and [2] overflow.
- R5: With ovf_mask_i=1, a finite result beyond the destination range sets flags_o[2] and flags_o[0] and is stored. It becomes infinity when the rounding direction leads away from zero, and the largest finite value of that sign otherwise.
- R6: With ovf_mask_i=0, an overflowing conversion sets flags_o[2] only and drives store_en_o low.
- R7: A finite result whose exponent falls below the destination's normal range is produced as a correctly rounded denormal or zero, and may round up to the smallest normal. It sets flags_o[1] when it is inexact, or whenever unf_mask_i=0. No other fault is signalled for it.
- R8: Zero and infinity inputs give a zero or infinity of the same sign, with no flag raised.
- R9: NaN inputs keep their sign and their top fraction bits, truncated to the destination fraction width. The quiet bit stays in the top fraction bit. If the truncated fraction would be all zero, the top fraction bit is set. No flag is raised.
- R10: dbl_i=0 gives the single result in result_o[31:0] with result_o[63:32] zero; dbl_i=1 gives the double result in all 64 bits.
- R11: flags_o bits, once set, stay set through later conversions until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Conversion request |
| src_i | input | 80 | Source value: sign, 15-bit exponent, explicit integer bit, 63-bit fraction |
| dbl_i | input | 1 | 0 = single result, 1 = double result |
| rnd_i | input | 2 | Rounding control |
| unf_mask_i | input | 1 | 1 masks underflow |
| ovf_mask_i | input | 1 | 1 masks overflow |
| valid_o | output | 1 | Result valid, one clock after the request |
| result_o | output | 64 | Converted word |
| store_en_o | output | 1 | Result may be written |
| flags_o | output | 3 | Sticky flags {overflow, underflow, precision} |

## Verification
The hardest cases to reach from the ports are the two where rounding itself changes the exponent:
- a value just below the overflow threshold that rounds up into overflow;
- a tiny value that rounds up into the smallest normal number.

Both are reached by choosing a source exponent at the edge of the destination range together with a significand whose kept bits are all ones and whose guard bit is set. The 80-bit denormal input is reached with a zero exponent field. That input drives the alignment shifter past its full width, so every bit goes into the sticky bit and the rounding mode alone decides between zero and the smallest denormal.

// File: rtl/ext_fp_pkg.sv
package ext_fp_pkg;
  localparam int EXT_EW = 15;
  localparam int EXT_SW = 64;
  localparam int SGL_EW = 8;
  localparam int SGL_FW = 23;
  localparam int DBL_EW = 11;
  localparam int DBL_FW = 52;

  localparam int FLG_PREC = 0;
  localparam int FLG_UNF  = 1;
  localparam int FLG_OVF  = 2;
  localparam int FLG_W    = 3;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;
endpackage

// File: rtl/ext_unpack.sv
module ext_unpack #(
  parameter int EW = 15,
  parameter int SW = 64
) (
  input  logic [EW+SW:0] src_i,
  output logic           sign_o,
  output logic [EW-1:0]  exp_o,
  output logic [SW-1:0]  sig_o,
  output logic           zero_o,
  output logic           inf_o,
  output logic           nan_o
);
  logic exp_max, frac_nz;

  assign sign_o  = src_i[EW+SW];
  assign exp_o   = src_i[EW+SW-1:SW];
  assign sig_o   = src_i[SW-1:0];
  assign exp_max = &exp_o;
  // fraction below the explicit integer bit
  assign frac_nz = |sig_o[SW-2:0];

  assign zero_o = (exp_o == '0) && (sig_o == '0);
  assign inf_o  = exp_max && !frac_nz;
  assign nan_o  = exp_max && frac_nz;
endmodule

// File: rtl/fp_narrow.sv
module fp_narrow
  import ext_fp_pkg::*;
#(
  parameter int EW    = 8,
  parameter int FW    = 23,
  parameter int IN_EW = 15,
  parameter int IN_SW = 64
) (
  input  logic             sign_i,
  input  logic [IN_EW-1:0] exp_i,
  input  logic [IN_SW-1:0] sig_i,
  input  logic             zero_i,
  input  logic             inf_i,
  input  logic             nan_i,
  input  logic [1:0]       rnd_i,
  input  logic             unf_mask_i,
  input  logic             ovf_mask_i,
  output logic [EW+FW:0]   res_o,
  output logic             prec_o,
  output logic             unf_o,
  output logic             ovf_o,
  output logic             store_ok_o
);
  localparam int IN_BIAS  = 2**(IN_EW-1) - 1;
  localparam int OUT_BIAS = 2**(EW-1) - 1;
  localparam int EXP_ALL  = 2**EW - 1;
  localparam int DW       = IN_EW + 3;
  localparam int SHW      = $clog2(IN_SW + 1);

  logic [IN_EW-1:0]     be;
  logic signed [DW-1:0] ed, under, exp_fin;
  logic                 tiny;
  logic [SHW-1:0]       sh;
  logic [IN_SW-1:0]     sh_sig;
  logic                 lost;
  logic [FW:0]          kept;
  logic                 guard, sticky, inexact, inc, ovf_raw, away;
  logic [FW+1:0]        rounded;
  logic [FW-1:0]        nan_frac;

  // true exponent rebased to destination; denormal source uses exponent 1
  assign be    = (exp_i == '0) ? IN_EW'(1) : exp_i;
  assign ed    = $signed({3'b000, be}) - DW'(IN_BIAS) + DW'(OUT_BIAS);
  assign tiny  = (ed <= DW'(0));
  assign under = DW'(1) - ed;

  always_comb begin
    if (!tiny)                    sh = '0;
    else if (under >= DW'(IN_SW)) sh = SHW'(IN_SW);
    else                          sh = under[SHW-1:0];
  end

  always_comb begin
    if (sh >= SHW'(IN_SW)) begin
      sh_sig = '0;
      lost   = |sig_i;
    end else begin
      sh_sig = sig_i >> sh;
      lost   = |(sig_i & ~({IN_SW{1'b1}} << sh));
    end
  end

  assign kept    = sh_sig[IN_SW-1 -: FW+1];
  assign guard   = sh_sig[IN_SW-2-FW];
  assign sticky  = (|sh_sig[IN_SW-3-FW:0]) | lost;
  assign inexact = guard | sticky;

  always_comb begin
    unique case (rnd_e'(rnd_i))
      RND_NEAR: inc = guard & (sticky | kept[0]);
      RND_DOWN: inc = sign_i & inexact;
      RND_UP:   inc = !sign_i & inexact;
      default:  inc = 1'b0;
    endcase
  end

  assign rounded = {1'b0, kept} + (FW+2)'(inc);
  assign exp_fin = (tiny ? DW'(0) : ed - DW'(1))
                 + $signed({{(DW-2){1'b0}}, rounded[FW+1:FW]});
  assign ovf_raw = !tiny && (exp_fin >= DW'(EXP_ALL));
  // overflow rounds to infinity when the rounding direction points away from zero
  assign away    = (rnd_e'(rnd_i) == RND_NEAR)
                || (rnd_e'(rnd_i) == RND_UP   && !sign_i)
                || (rnd_e'(rnd_i) == RND_DOWN &&  sign_i);

  always_comb begin
    nan_frac = sig_i[IN_SW-2 -: FW];
    if (nan_frac == '0) nan_frac[FW-1] = 1'b1;
  end

  always_comb begin
    prec_o     = 1'b0;
    unf_o      = 1'b0;
    ovf_o      = 1'b0;
    store_ok_o = 1'b1;
    if (nan_i) begin
      res_o = {sign_i, {EW{1'b1}}, nan_frac};
    end else if (inf_i) begin
      res_o = {sign_i, {EW{1'b1}}, {FW{1'b0}}};
    end else if (zero_i) begin
      res_o = {sign_i, {(EW+FW){1'b0}}};
    end else if (ovf_raw) begin
      ovf_o = 1'b1;
      if (ovf_mask_i) prec_o = 1'b1;
      else            store_ok_o = 1'b0;
      if (away) res_o = {sign_i, {EW{1'b1}}, {FW{1'b0}}};
      else      res_o = {sign_i, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
    end else begin
      res_o  = {sign_i, exp_fin[EW-1:0], rounded[FW-1:0]};
      prec_o = inexact;
      unf_o  = tiny && (inexact || !unf_mask_i);
    end
  end

  always_comb begin
    if (unf_o) begin
      AST_UNF_EXP_LOW: assert (res_o[EW+FW-1:FW] <= EW'(1)); // R7
    end
    if (!store_ok_o) begin
      AST_NOSTORE_IS_OVF: assert (ovf_o && !ovf_mask_i); // R6
    end
  end
endmodule

// File: rtl/ext_fp_store.sv
module ext_fp_store
  import ext_fp_pkg::*;
#(
  parameter int IN_EW = EXT_EW,
  parameter int IN_SW = EXT_SW,
  parameter int OUT_W = 1 + DBL_EW + DBL_FW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [IN_EW+IN_SW:0] src_i,
  input  logic                 dbl_i,
  input  logic [1:0]           rnd_i,
  input  logic                 unf_mask_i,
  input  logic                 ovf_mask_i,
  output logic                 valid_o,
  output logic [OUT_W-1:0]     result_o,
  output logic                 store_en_o,
  output logic [FLG_W-1:0]     flags_o
);
  localparam int NFMT = 2;

  logic             sign;
  logic [IN_EW-1:0] exp_v;
  logic [IN_SW-1:0] sig;
  logic             is_zero, is_inf, is_nan;

  logic [OUT_W-1:0] res_w  [NFMT];
  logic [FLG_W-1:0] flg_w  [NFMT];
  logic             stok_w [NFMT];
  logic             dbl_q;

  ext_unpack #(.EW(IN_EW), .SW(IN_SW)) u_unpack (
    .src_i  (src_i),
    .sign_o (sign),
    .exp_o  (exp_v),
    .sig_o  (sig),
    .zero_o (is_zero),
    .inf_o  (is_inf),
    .nan_o  (is_nan)
  );

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EW = (g == 0) ? SGL_EW : DBL_EW;
    localparam int FW = (g == 0) ? SGL_FW : DBL_FW;
    logic [EW+FW:0] res;
    logic           prec, unf, ovf, stok;

    fp_narrow #(.EW(EW), .FW(FW), .IN_EW(IN_EW), .IN_SW(IN_SW)) u_narrow (
      .sign_i     (sign),
      .exp_i      (exp_v),
      .sig_i      (sig),
      .zero_i     (is_zero),
      .inf_i      (is_inf),
      .nan_i      (is_nan),
      .rnd_i      (rnd_i),
      .unf_mask_i (unf_mask_i),
      .ovf_mask_i (ovf_mask_i),
      .res_o      (res),
      .prec_o     (prec),
      .unf_o      (unf),
      .ovf_o      (ovf),
      .store_ok_o (stok)
    );

    assign res_w[g]  = OUT_W'(res);
    assign flg_w[g]  = {ovf, unf, prec};
    assign stok_w[g] = stok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      store_en_o <= 1'b0;
      flags_o    <= '0;
      dbl_q      <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      store_en_o <= valid_i && stok_w[dbl_i];
      if (valid_i) begin
        result_o <= res_w[dbl_i];
        flags_o  <= flags_o | flg_w[dbl_i];
        dbl_q    <= dbl_i;
      end
    end
  end

  AST_OVF_BLOCKS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !store_en_o) |-> flags_o[FLG_OVF]); // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R11
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dbl_q) |-> (result_o[OUT_W-1:32] == '0)); // R10
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_STORE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !store_en_o); // R2
endmodule

// File: tb/tb_ext_fp_store.sv
`timescale 1ns/1ps
module tb_ext_fp_store;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [79:0] src_i = '0;
  logic        dbl_i = 1'b0;
  logic [1:0]  rnd_i = 2'b00;
  logic        unf_mask_i = 1'b1;
  logic        ovf_mask_i = 1'b1;
  logic        valid_o;
  logic [63:0] result_o;
  logic        store_en_o;
  logic [2:0]  flags_o;

  int n_checks = 0;
  int n_fail   = 0;

  ext_fp_store dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .src_i      (src_i),
    .dbl_i      (dbl_i),
    .rnd_i      (rnd_i),
    .unf_mask_i (unf_mask_i),
    .ovf_mask_i (ovf_mask_i),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .store_en_o (store_en_o),
    .flags_o    (flags_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [79:0] x80(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // result is registered at the posedge between the two negedges
  task automatic op(input logic [79:0] x, input logic dbl, input logic [1:0] rm,
                    input logic um, input logic om);
    @(negedge clk_i);
    src_i = x; dbl_i = dbl; rnd_i = rm; unf_mask_i = um; ovf_mask_i = om;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run(input string tag, input logic [79:0] x, input logic dbl,
                     input logic [1:0] rm, input logic um, input logic om,
                     input logic [63:0] er, input logic es, input logic [2:0] ef);
    do_reset();
    op(x, dbl, rm, um, om);
    chk({tag, " valid"}, 64'(valid_o), 64'(1'b1));
    chk({tag, " result"}, result_o, er);
    chk({tag, " store"}, 64'(store_en_o), 64'(es));
    chk({tag, " flags"}, 64'(flags_o), 64'(ef));
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #3;
    chk("R1 valid", 64'(valid_o), 64'(0));
    chk("R1 result", result_o, 64'(0));
    chk("R1 store", 64'(store_en_o), 64'(0));
    chk("R1 flags", 64'(flags_o), 64'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle valid", 64'(valid_o), 64'(0));
  endtask

  task automatic t_exact();
    run("R2 R10 single 1.5", x80(0, 15'd16383, 64'hC000_0000_0000_0000), 0, 2'b00, 1, 1,
        64'h0000_0000_3FC0_0000, 1, 3'b000);
    run("R2 R10 double 1.5", x80(0, 15'd16383, 64'hC000_0000_0000_0000), 1, 2'b00, 1, 1,
        64'h3FF8_0000_0000_0000, 1, 3'b000);
  endtask

  task automatic t_round();
    logic [79:0] tie_odd, tie_even, carry, dsub;
    tie_odd  = x80(0, 15'd16383, 64'h8000_0180_0000_0000);
    tie_even = x80(0, 15'd16383, 64'h8000_0080_0000_0000);
    carry    = x80(0, 15'd16383, 64'hFFFF_FF80_0000_0000);
    dsub     = x80(0, 15'd16383, 64'hC000_0000_0000_0001);
    run("R3 R4 near tie odd",  tie_odd, 0, 2'b00, 1, 1, 64'h3F80_0002, 1, 3'b001);
    run("R3 R4 near tie even", tie_even, 0, 2'b00, 1, 1, 64'h3F80_0000, 1, 3'b001);
    run("R3 down pos",  tie_odd, 0, 2'b01, 1, 1, 64'h3F80_0001, 1, 3'b001);
    run("R3 up pos",    tie_odd, 0, 2'b10, 1, 1, 64'h3F80_0002, 1, 3'b001);
    run("R3 zero pos",  tie_odd, 0, 2'b11, 1, 1, 64'h3F80_0001, 1, 3'b001);
    run("R3 down neg",  {1'b1, tie_odd[78:0]}, 0, 2'b01, 1, 1, 64'hBF80_0002, 1, 3'b001);
    run("R3 up neg",    {1'b1, tie_odd[78:0]}, 0, 2'b10, 1, 1, 64'hBF80_0001, 1, 3'b001);
    run("R3 carry exp", carry, 0, 2'b00, 1, 1, 64'h4000_0000, 1, 3'b001);
    run("R3 R4 dbl sticky near", dsub, 1, 2'b00, 1, 1, 64'h3FF8_0000_0000_0000, 1, 3'b001);
    run("R3 R4 dbl sticky up",   dsub, 1, 2'b10, 1, 1, 64'h3FF8_0000_0000_0001, 1, 3'b001);
  endtask

  task automatic t_ovf_masked();
    logic [79:0] big, edge_v;
    big    = x80(0, 15'd16511, 64'h8000_0000_0000_0000);
    edge_v = x80(0, 15'd16510, 64'hFFFF_FF80_0000_0000);
    run("R5 near inf",      big, 0, 2'b00, 1, 1, 64'h7F80_0000, 1, 3'b101);
    run("R5 zero maxfin",   big, 0, 2'b11, 1, 1, 64'h7F7F_FFFF, 1, 3'b101);
    run("R5 neg up maxfin", {1'b1, big[78:0]}, 0, 2'b10, 1, 1, 64'hFF7F_FFFF, 1, 3'b101);
    run("R5 neg down inf",  {1'b1, big[78:0]}, 0, 2'b01, 1, 1, 64'hFF80_0000, 1, 3'b101);
    run("R5 round into ovf", edge_v, 0, 2'b00, 1, 1, 64'h7F80_0000, 1, 3'b101);
  endtask

  task automatic t_ovf_unmasked();
    do_reset();
    op(x80(0, 15'd16511, 64'h8000_0000_0000_0000), 0, 2'b00, 1, 0);
    chk("R6 valid", 64'(valid_o), 64'(1));
    chk("R6 store blocked", 64'(store_en_o), 64'(0));
    chk("R6 flags", 64'(flags_o), 64'(3'b100));
  endtask

  task automatic t_tiny();
    run("R7 exact denorm masked",   x80(0, 15'd16256, 64'h8000_0000_0000_0000), 0, 2'b00, 1, 1,
        64'h0040_0000, 1, 3'b000);
    run("R7 exact denorm unmasked", x80(0, 15'd16256, 64'h8000_0000_0000_0000), 0, 2'b00, 0, 1,
        64'h0040_0000, 1, 3'b010);
    run("R7 half min near",         x80(0, 15'd16233, 64'h8000_0000_0000_0000), 0, 2'b00, 1, 1,
        64'h0000_0000, 1, 3'b011);
    run("R7 half min up",           x80(0, 15'd16233, 64'h8000_0000_0000_0000), 0, 2'b10, 1, 1,
        64'h0000_0001, 1, 3'b011);
    run("R7 round to min normal",   x80(0, 15'd16256, 64'hFFFF_FFFF_0000_0000), 0, 2'b00, 1, 1,
        64'h0080_0000, 1, 3'b011);
    run("R7 src denorm near",       x80(0, 15'd0, 64'h0000_0000_0000_0001), 0, 2'b00, 1, 1,
        64'h0000_0000, 1, 3'b011);
    run("R7 src denorm up",         x80(0, 15'd0, 64'h0000_0000_0000_0001), 0, 2'b10, 1, 1,
        64'h0000_0001, 1, 3'b011);
  endtask

  task automatic t_special();
    run("R8 neg zero single", x80(1, 15'd0, 64'h0), 0, 2'b00, 1, 1, 64'h8000_0000, 1, 3'b000);
    run("R8 neg zero double", x80(1, 15'd0, 64'h0), 1, 2'b10, 1, 1, 64'h8000_0000_0000_0000, 1, 3'b000);
    run("R8 inf single", x80(0, 15'h7FFF, 64'h8000_0000_0000_0000), 0, 2'b11, 1, 0,
        64'h7F80_0000, 1, 3'b000);
    run("R8 neg inf double", x80(1, 15'h7FFF, 64'h8000_0000_0000_0000), 1, 2'b00, 1, 0,
        64'hFFF0_0000_0000_0000, 1, 3'b000);
  endtask

  task automatic t_nan();
    run("R9 qnan single", x80(0, 15'h7FFF, 64'hC000_0000_0000_1234), 0, 2'b00, 1, 1,
        64'h7FC0_0000, 1, 3'b000);
    run("R9 low payload single", x80(1, 15'h7FFF, 64'h8000_0000_0000_0001), 0, 2'b00, 1, 1,
        64'hFFC0_0000, 1, 3'b000);
    run("R9 nan double", x80(0, 15'h7FFF, 64'hE000_0000_0000_0800), 1, 2'b00, 1, 1,
        64'h7FFC_0000_0000_0001, 1, 3'b000);
  endtask

  task automatic t_sticky();
    do_reset();
    op(x80(0, 15'd16511, 64'h8000_0000_0000_0000), 0, 2'b00, 1, 1);
    chk("R11 first flags", 64'(flags_o), 64'(3'b101));
    op(x80(0, 15'd16383, 64'hC000_0000_0000_0000), 0, 2'b00, 1, 1);
    chk("R11 exact result", result_o, 64'h3FC0_0000);
    chk("R11 flags kept", 64'(flags_o), 64'(3'b101));
    op(x80(0, 15'd16233, 64'h8000_0000_0000_0000), 0, 2'b00, 1, 1);
    chk("R11 flags merged", 64'(flags_o), 64'(3'b111));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog actual %0d cycles expected completion", 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_round();
    t_ovf_masked();
    t_ovf_unmasked();
    t_tiny();
    t_special();
    t_nan();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule